// File: doc/BRIEF.md
# Processor Exception Control Unit

This unit is the system-control slice of a small 32-bit RISC core. It keeps four registers: a status word, a cause word, the restart address (EPC) and the last faulting data address. Each cycle, the execute stage presents one instruction together with its request lines: system call, address fault, coprocessor access, register moves and return-from-exception. The external interrupt lines arrive on the same cycle. The unit decides in that same cycle whether an exception is taken. If one is, it asserts a fetch redirect to a fixed vector. At the next clock edge it records the restart point, the reason and the delay-slot flag, and it pushes the privilege/interrupt-enable stack.

The status word holds a three-level stack of (privilege, interrupt-enable) pairs: current, previous and old. Taking an exception pushes the stack and enters kernel mode with interrupts off. A return-from-exception pops the stack and restores the earlier pair. Moves into and out of the unit, and the return operation, are honoured only in kernel mode. Attempting any of them in user mode traps.

Top module: `excu_top`

## Requirements
- R1: After a synchronous reset, status, cause, EPC and the fault-address register all read 0. The unit is therefore in kernel mode with interrupts disabled, and no redirect is asserted while no request is present.
- R2: Taking an exception shifts the stack at the next edge. Status bits [5:4] (old) take bits [3:2] (previous), bits [3:2] take bits [1:0] (current), and bits [1:0] become 00. In each pair the upper bit is privilege (1 = user) and the lower bit is interrupt-enable.
- R3: A kernel-mode return-from-exception with no exception taken shifts the stack back. Current takes previous, previous takes old, and old keeps its value.
- R4: On an exception, EPC receives the instruction address, or that address minus 4 when the delay-slot input is set. Cause bit 31 records the delay-slot flag.
- R5: Cause bits [6:2] hold the code of the exception taken: interrupt 0, address fault 4, system call 8, coprocessor unusable 11.
- R6: In the cycle a request is accepted, `redirect` is high and `redirect_pc` equals 0x80000080.
- R7: An interrupt is taken only when `ex_valid` is high, status bit 0 is 1, and some pending bit is set with its mask bit set. Cause bits [15:8] show the pending bits live: [15:10] are `irq_lines[5:0]` and [9:8] are the two software bits. Status bits [15:8] are the per-line masks.
- R8: When several requests coincide, the code recorded follows the priority interrupt > address fault > coprocessor unusable > system call.
- R9: A register write, a register read or a return-from-exception attempted in user mode raises code 11 with cause bits [29:28] = 0. It changes no register other than the exception state, and a read returns 0.
- R10: Register index 8 is the fault address. It is loaded only by a taken address fault and ignores writes. Index 11 is status, with bits [15:8] and [5:0] writable. Index 13 is cause, where only bits [9:8] are writable. Index 14 is EPC, which is writable. Reads of any other index return 0.
- R11: An access to a nonzero coprocessor number (`ex_cop_num` ≠ 0) raises code 11, and cause bits [29:28] report that number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 6 | External interrupt lines, level |
| ex_valid | input | 1 | A valid instruction is in the execute stage |
| ex_pc | input | 32 | Address of that instruction |
| ex_in_delay | input | 1 | Instruction sits in a branch delay slot |
| ex_syscall | input | 1 | System call request |
| ex_addr_err | input | 1 | Address fault request |
| ex_bad_vaddr | input | 32 | Faulting data address |
| ex_cop_num | input | 2 | Coprocessor addressed (0 = none/this unit) |
| ex_mtc0 | input | 1 | Move into a unit register |
| ex_mfc0 | input | 1 | Move out of a unit register |
| ex_rfe | input | 1 | Return-from-exception |
| reg_idx | input | 5 | Register index for moves |
| wr_data | input | 32 | Data for a move into the unit |
| rd_data | output | 32 | Data of a move out of the unit |
| redirect | output | 1 | Exception accepted this cycle |
| redirect_pc | output | 32 | Fetch address while redirect is high |
| kernel_mode | output | 1 | Current privilege is kernel |
| int_enable | output | 1 | Current interrupt enable |

## Verification
The assertions rely on the pipeline keeping request lines quiet unless `ex_valid` is high. They also assume the request lines, `ex_pc` and the delay-slot flag are stable from before the active edge until after it. The bench drives every request from a negative clock edge and returns all of them to idle after the following positive edge. Interrupt lines are cleared before each return-from-exception, so the pending state the checks expect is always the one that was driven. Register reads are made with no edge in between, so a read never disturbs the state it observes.

// File: rtl/excu_pkg.sv
`timescale 1ns/1ps
package excu_pkg;
    localparam int XLEN        = 32;
    localparam int N_EXT       = 6;
    localparam int N_SW        = 2;
    localparam int N_IRQ       = N_EXT + N_SW;
    localparam int STACK_DEPTH = 3;
    localparam int IDX_W       = 5;

    // bit positions software relies on
    localparam int IM_LSB   = 8;   // status mask and cause pending share this lane
    localparam int CODE_LSB = 2;
    localparam int CODE_W   = 5;
    localparam int CE_LSB   = 28;
    localparam int BD_BIT   = 31;

    localparam logic [IDX_W-1:0] IDX_BADVA  = 5'd8;
    localparam logic [IDX_W-1:0] IDX_STATUS = 5'd11;
    localparam logic [IDX_W-1:0] IDX_CAUSE  = 5'd13;
    localparam logic [IDX_W-1:0] IDX_EPC    = 5'd14;

    typedef enum logic [CODE_W-1:0] {
        EXC_INT  = 5'd0,
        EXC_ADDR = 5'd4,
        EXC_SYS  = 5'd8,
        EXC_CPU  = 5'd11
    } exc_code_e;

    // request slots in descending priority
    localparam int SRC_INT  = 0;
    localparam int SRC_ADDR = 1;
    localparam int SRC_CPU  = 2;
    localparam int SRC_SYS  = 3;
    localparam int N_SRC    = 4;

    typedef struct packed {
        logic ku;
        logic ie;
    } mode_t;

    typedef struct packed {
        logic      take;
        exc_code_e code;
        logic [1:0] ce;
    } exc_evt_t;

    function automatic exc_code_e src_code(input int s);
        case (s)
            SRC_INT:  return EXC_INT;
            SRC_ADDR: return EXC_ADDR;
            SRC_CPU:  return EXC_CPU;
            default:  return EXC_SYS;
        endcase
    endfunction
endpackage

// File: rtl/excu_arbiter.sv
`timescale 1ns/1ps
module excu_arbiter
    import excu_pkg::*;
(
    input  logic [N_SRC-1:0] req,
    input  logic [1:0]       ce_in,
    output exc_evt_t         evt
);
    logic [N_SRC-1:0] grant;

    always_comb begin
        grant = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (req[s] && (grant == '0)) grant[s] = 1'b1;
        end
    end

    always_comb begin
        evt.take = |req;
        evt.code = EXC_INT;
        evt.ce   = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (grant[s]) evt.code = src_code(s);
        end
        if (grant[SRC_CPU]) evt.ce = ce_in;
    end
endmodule

// File: rtl/excu_status.sv
`timescale 1ns/1ps
module excu_status
    import excu_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     take,
    input  logic                     rfe,
    input  logic                     wr_en,
    input  logic [N_IRQ-1:0]         wr_mask,
    input  logic [2*STACK_DEPTH-1:0] wr_stack,
    output logic [XLEN-1:0]          word,
    output logic                     kernel,
    output logic                     ie_cur,
    output logic [N_IRQ-1:0]         im
);
    mode_t            stk [STACK_DEPTH];
    logic [N_IRQ-1:0] im_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STACK_DEPTH; i++) stk[i] <= '0;
            im_q <= '0;
        end else if (take) begin
            stk[0] <= '0;
            for (int i = 1; i < STACK_DEPTH; i++) stk[i] <= stk[i-1];
        end else if (rfe) begin
            for (int i = 0; i < STACK_DEPTH-1; i++) stk[i] <= stk[i+1];
        end else if (wr_en) begin
            for (int i = 0; i < STACK_DEPTH; i++) stk[i] <= mode_t'(wr_stack[2*i +: 2]);
            im_q <= wr_mask;
        end
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < STACK_DEPTH; i++) word[2*i +: 2] = stk[i];
        word[IM_LSB +: N_IRQ] = im_q;
    end

    assign kernel = ~stk[0].ku;
    assign ie_cur = stk[0].ie;
    assign im     = im_q;

    // R2
    push_cur_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (kernel && !ie_cur));
    // R2
    push_old_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> stk[STACK_DEPTH-1] == $past(stk[STACK_DEPTH-2]));
    // R3
    pop_chk: assert property (@(posedge clk) disable iff (rst)
        (rfe && !take) |=> (stk[0] == $past(stk[1])) && (stk[STACK_DEPTH-1] == $past(stk[STACK_DEPTH-1])));
endmodule

// File: rtl/excu_cause.sv
`timescale 1ns/1ps
module excu_cause
    import excu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  exc_evt_t         evt,
    input  logic             bd_in,
    input  logic [N_EXT-1:0] irq_lines,
    input  logic             sw_wr_en,
    input  logic [N_SW-1:0]  sw_wr_data,
    output logic [XLEN-1:0]  word,
    output logic [N_IRQ-1:0] ip
);
    exc_code_e       code_q;
    logic            bd_q;
    logic [1:0]      ce_q;
    logic [N_SW-1:0] sw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= EXC_INT;
            bd_q   <= 1'b0;
            ce_q   <= '0;
            sw_q   <= '0;
        end else begin
            if (evt.take) begin
                code_q <= evt.code;
                bd_q   <= bd_in;
                ce_q   <= evt.ce;
            end
            if (sw_wr_en) sw_q <= sw_wr_data;
        end
    end

    assign ip = {irq_lines, sw_q};

    always_comb begin
        word = '0;
        word[BD_BIT]                = bd_q;
        word[CE_LSB +: 2]           = ce_q;
        word[IM_LSB +: N_IRQ]       = ip;
        word[CODE_LSB +: CODE_W]    = code_q;
    end

    // R5
    code_latch_chk: assert property (@(posedge clk) disable iff (rst)
        evt.take |=> word[CODE_LSB +: CODE_W] == $past(evt.code));
    // R4
    bd_latch_chk: assert property (@(posedge clk) disable iff (rst)
        evt.take |=> word[BD_BIT] == $past(bd_in));
endmodule

// File: rtl/excu_top.sv
`timescale 1ns/1ps
module excu_top
    import excu_pkg::*;
#(
    parameter logic [31:0] VECTOR_ADDR  = 32'h8000_0080,
    parameter int          BRANCH_BYTES = 4
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [5:0]       irq_lines,
    input  logic             ex_valid,
    input  logic [31:0]      ex_pc,
    input  logic             ex_in_delay,
    input  logic             ex_syscall,
    input  logic             ex_addr_err,
    input  logic [31:0]      ex_bad_vaddr,
    input  logic [1:0]       ex_cop_num,
    input  logic             ex_mtc0,
    input  logic             ex_mfc0,
    input  logic             ex_rfe,
    input  logic [4:0]       reg_idx,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    output logic             redirect,
    output logic [31:0]      redirect_pc,
    output logic             kernel_mode,
    output logic             int_enable
);
    logic [XLEN-1:0]  status_word, cause_word, epc_q, badva_q;
    logic [N_IRQ-1:0] ip_vec, im_vec;
    logic             kernel, ie_cur;
    logic             int_req, addr_req, cpu_req, sys_req, move_op;
    logic [N_SRC-1:0] req;
    exc_evt_t         evt;
    logic             take, wr_fire, rfe_fire;

    assign move_op  = ex_mtc0 | ex_mfc0 | ex_rfe;
    assign int_req  = ex_valid & ie_cur & |(ip_vec & im_vec);
    assign addr_req = ex_valid & ex_addr_err;
    assign cpu_req  = ex_valid & ((ex_cop_num != 2'd0) | (~kernel & move_op));
    assign sys_req  = ex_valid & ex_syscall;

    always_comb begin
        req           = '0;
        req[SRC_INT]  = int_req;
        req[SRC_ADDR] = addr_req;
        req[SRC_CPU]  = cpu_req;
        req[SRC_SYS]  = sys_req;
    end

    excu_arbiter u_arb (
        .req   (req),
        .ce_in (ex_cop_num),
        .evt   (evt)
    );

    assign take     = evt.take;
    assign wr_fire  = ex_valid & ex_mtc0 & kernel & ~take;
    assign rfe_fire = ex_valid & ex_rfe & kernel & ~take;

    excu_status u_status (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .rfe      (rfe_fire),
        .wr_en    (wr_fire && (reg_idx == IDX_STATUS)),
        .wr_mask  (wr_data[IM_LSB +: N_IRQ]),
        .wr_stack (wr_data[2*STACK_DEPTH-1:0]),
        .word     (status_word),
        .kernel   (kernel),
        .ie_cur   (ie_cur),
        .im       (im_vec)
    );

    excu_cause u_cause (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .bd_in      (ex_in_delay),
        .irq_lines  (irq_lines),
        .sw_wr_en   (wr_fire && (reg_idx == IDX_CAUSE)),
        .sw_wr_data (wr_data[IM_LSB +: N_SW]),
        .word       (cause_word),
        .ip         (ip_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q   <= '0;
            badva_q <= '0;
        end else begin
            if (take)
                epc_q <= ex_in_delay ? (ex_pc - XLEN'(BRANCH_BYTES)) : ex_pc;
            else if (wr_fire && (reg_idx == IDX_EPC))
                epc_q <= wr_data;
            if (take && (evt.code == EXC_ADDR))
                badva_q <= ex_bad_vaddr;
        end
    end

    always_comb begin
        rd_data = '0;
        if (ex_mfc0 && kernel) begin
            case (reg_idx)
                IDX_BADVA:  rd_data = badva_q;
                IDX_STATUS: rd_data = status_word;
                IDX_CAUSE:  rd_data = cause_word;
                IDX_EPC:    rd_data = epc_q;
                default:    rd_data = '0;
            endcase
        end
    end

    assign redirect    = take;
    assign redirect_pc = take ? VECTOR_ADDR : '0;
    assign kernel_mode = kernel;
    assign int_enable  = ie_cur;

    // R4
    epc_capture_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> epc_q == ($past(ex_in_delay) ? $past(ex_pc) - 32'd4 : $past(ex_pc)));
    // R9
    user_move_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && !kernel_mode && move_op) |-> redirect);
    // R9
    user_move_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && !kernel_mode && ex_mtc0) |=> $stable(status_word[IM_LSB +: N_IRQ]));
    // R8
    prio_int_chk: assert property (@(posedge clk) disable iff (rst)
        int_req |=> cause_word[CODE_LSB +: CODE_W] == 5'd0);
    // R3
    rfe_restore_chk: assert property (@(posedge clk) disable iff (rst)
        rfe_fire |=> kernel_mode == !$past(status_word[3]));
    // R10
    badva_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(take && ex_addr_err) |=> $stable(badva_q));
    // R7
    int_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && !int_enable && !ex_syscall && !ex_addr_err && (ex_cop_num == 2'd0)
         && !move_op) |-> !redirect);
endmodule

// File: tb/excu_top_tb.sv
`timescale 1ns/1ps
module excu_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  irq_lines;
    logic        ex_valid, ex_in_delay, ex_syscall, ex_addr_err;
    logic [31:0] ex_pc, ex_bad_vaddr, wr_data;
    logic [1:0]  ex_cop_num;
    logic        ex_mtc0, ex_mfc0, ex_rfe;
    logic [4:0]  reg_idx;
    logic [31:0] rd_data, redirect_pc;
    logic        redirect, kernel_mode, int_enable;

    int checks = 0;
    int failures = 0;
    logic        seen_redir;
    logic [31:0] seen_pc;
    logic [31:0] rv;

    always #10 clk = ~clk;

    excu_top u_dut (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .ex_valid(ex_valid),
        .ex_pc(ex_pc), .ex_in_delay(ex_in_delay), .ex_syscall(ex_syscall),
        .ex_addr_err(ex_addr_err), .ex_bad_vaddr(ex_bad_vaddr),
        .ex_cop_num(ex_cop_num), .ex_mtc0(ex_mtc0), .ex_mfc0(ex_mfc0),
        .ex_rfe(ex_rfe), .reg_idx(reg_idx), .wr_data(wr_data),
        .rd_data(rd_data), .redirect(redirect), .redirect_pc(redirect_pc),
        .kernel_mode(kernel_mode), .int_enable(int_enable)
    );

    // row: [15:10] irq, [9] addr, [8:7] cop, [6] sys, [5] take, [4:0] code
    localparam int N_VEC = 8;
    localparam logic [15:0] VEC [N_VEC] = '{
        {6'b000001, 1'b0, 2'd0, 1'b0, 1'b1, 5'd0},
        {6'b000000, 1'b0, 2'd0, 1'b1, 1'b1, 5'd8},
        {6'b000000, 1'b1, 2'd0, 1'b0, 1'b1, 5'd4},
        {6'b000000, 1'b0, 2'd2, 1'b0, 1'b1, 5'd11},
        {6'b000000, 1'b1, 2'd0, 1'b1, 1'b1, 5'd4},
        {6'b100000, 1'b1, 2'd0, 1'b1, 1'b1, 5'd0},
        {6'b000000, 1'b0, 2'd3, 1'b1, 1'b1, 5'd11},
        {6'b000000, 1'b0, 2'd0, 1'b0, 1'b0, 5'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        irq_lines = '0; ex_valid = 0; ex_pc = '0; ex_in_delay = 0;
        ex_syscall = 0; ex_addr_err = 0; ex_bad_vaddr = '0; ex_cop_num = '0;
        ex_mtc0 = 0; ex_mfc0 = 0; ex_rfe = 0; reg_idx = '0; wr_data = '0;
    endtask

    task automatic issue(input logic [5:0] irq, input logic [31:0] pc, input logic bd,
                         input logic sys, input logic addr, input logic [31:0] va,
                         input logic [1:0] cop, input logic rfe, input logic mtc0,
                         input logic [4:0] idx, input logic [31:0] data);
        @(negedge clk);
        irq_lines = irq; ex_valid = 1; ex_pc = pc; ex_in_delay = bd;
        ex_syscall = sys; ex_addr_err = addr; ex_bad_vaddr = va; ex_cop_num = cop;
        ex_rfe = rfe; ex_mtc0 = mtc0; reg_idx = idx; wr_data = data;
        #1;
        seen_redir = redirect;
        seen_pc    = redirect_pc;
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic rd(input logic [4:0] idx, output logic [31:0] val);
        @(negedge clk);
        ex_valid = 1; ex_mfc0 = 1; reg_idx = idx;
        #1;
        val = rd_data;
        seen_redir = redirect;
        idle();
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] data);
        issue('0, 32'h0, 0, 0, 0, '0, 2'd0, 0, 1, idx, data);
    endtask

    task automatic sysc(input logic [31:0] pc, input logic bd);
        issue('0, pc, bd, 1, 0, '0, 2'd0, 0, 0, '0, '0);
    endtask

    task automatic do_rfe();
        issue('0, 32'h0, 0, 0, 0, '0, 2'd0, 1, 0, '0, '0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        #1;
        chk("R1 redirect", {31'd0, redirect}, 32'd0);
        chk("R1 kernel", {31'd0, kernel_mode}, 32'd1);
        chk("R1 ie", {31'd0, int_enable}, 32'd0);
        rd(5'd11, rv); chk("R1 status", rv, 32'd0);
        rd(5'd13, rv); chk("R1 cause", rv, 32'd0);
        rd(5'd14, rv); chk("R1 epc", rv, 32'd0);
        rd(5'd8,  rv); chk("R1 badva", rv, 32'd0);

        // table walk: kernel, IE on, all lines unmasked
        wr(5'd11, 32'h0000_FF01);
        for (int i = 0; i < N_VEC; i++) begin
            logic [15:0] v;
            logic [31:0] pc;
            v  = VEC[i];
            pc = 32'h0000_1000 + 32'(i) * 4;
            issue(v[15:10], pc, 0, v[6], v[9], 32'h0000_0040, v[8:7], 0, 0, '0, '0);
            chk("R7/R8 take", {31'd0, seen_redir}, {31'd0, v[5]});
            if (v[5]) begin
                chk("R6 vector", seen_pc, 32'h8000_0080);
                rd(5'd13, rv);
                chk("R5/R8 code", {27'd0, rv[6:2]}, {27'd0, v[4:0]});
                if (v[4:0] == 5'd11) chk("R11 ce", {30'd0, rv[29:28]}, {30'd0, v[8:7]});
                rd(5'd14, rv); chk("R4 epc", rv, pc);
                rd(5'd11, rv); chk("R2 push", rv, 32'h0000_FF04);
                do_rfe();
                rd(5'd11, rv); chk("R3 pop", rv, 32'h0000_FF01);
            end
        end

        // R4 delay slot
        sysc(32'h0000_0200, 1);
        rd(5'd14, rv); chk("R4 bd epc", rv, 32'h0000_01FC);
        rd(5'd13, rv); chk("R4 bd flag", {31'd0, rv[31]}, 32'd1);
        do_rfe();

        // R7 masking
        wr(5'd11, 32'h0000_7F01);
        issue(6'b100000, 32'h300, 0, 0, 0, '0, 2'd0, 0, 0, '0, '0);
        chk("R7 masked line", {31'd0, seen_redir}, 32'd0);
        issue(6'b010000, 32'h304, 0, 0, 0, '0, 2'd0, 0, 0, '0, '0);
        chk("R7 unmasked line", {31'd0, seen_redir}, 32'd1);
        do_rfe();
        wr(5'd11, 32'h0000_FF00);
        issue(6'b000001, 32'h308, 0, 0, 0, '0, 2'd0, 0, 0, '0, '0);
        chk("R7 ie off", {31'd0, seen_redir}, 32'd0);

        // R10 cause write mask, then software interrupt
        wr(5'd13, 32'hFFFF_FFFF);
        rd(5'd13, rv); chk("R10 cause mask", rv, 32'h0000_0300);
        wr(5'd11, 32'h0000_FF01);
        issue('0, 32'h310, 0, 0, 0, '0, 2'd0, 0, 0, '0, '0);
        chk("R7 soft int", {31'd0, seen_redir}, 32'd1);
        wr(5'd13, 32'h0);
        do_rfe();

        // R10 fault address register
        issue('0, 32'h400, 0, 0, 1, 32'hDEAD_BEE0, 2'd0, 0, 0, '0, '0);
        rd(5'd8, rv); chk("R10 badva load", rv, 32'hDEAD_BEE0);
        wr(5'd8, 32'h0000_1234);
        rd(5'd8, rv); chk("R10 badva ro", rv, 32'hDEAD_BEE0);
        rd(5'd5, rv); chk("R10 unmapped", rv, 32'd0);
        wr(5'd14, 32'h0000_ABC0);
        rd(5'd14, rv); chk("R10 epc write", rv, 32'h0000_ABC0);
        do_rfe();

        // R2/R3 nesting through old level
        wr(5'd11, 32'h0000_0001);
        sysc(32'h500, 0);
        rd(5'd11, rv); chk("R2 nest1", rv, 32'h0000_0004);
        sysc(32'h504, 0);
        rd(5'd11, rv); chk("R2 nest2", rv, 32'h0000_0010);
        do_rfe();
        rd(5'd11, rv); chk("R3 unnest1", rv, 32'h0000_0014);
        do_rfe();
        rd(5'd11, rv); chk("R3 unnest2", rv, 32'h0000_0015);

        // R9 user mode moves
        wr(5'd11, 32'h0000_0002);
        #1;
        chk("R9 user mode", {31'd0, kernel_mode}, 32'd0);
        rd(5'd11, rv);
        chk("R9 user read", rv, 32'd0);
        chk("R9 user read trap", {31'd0, seen_redir}, 32'd1);
        issue('0, 32'h600, 0, 0, 0, '0, 2'd0, 0, 1, 5'd11, 32'h0000_FF03);
        chk("R9 user write trap", {31'd0, seen_redir}, 32'd1);
        rd(5'd11, rv); chk("R9 write blocked", rv, 32'h0000_0008);
        rd(5'd13, rv); chk("R9 code ce", rv & 32'h3000_007C, 32'h0000_002C);
        do_rfe();
        #1;
        chk("R3 back to user", {31'd0, kernel_mode}, 32'd0);
        do_rfe();
        chk("R9 user rfe trap", {31'd0, seen_redir}, 32'd1);
        #1;
        chk("R9 user rfe kernel", {31'd0, kernel_mode}, 32'd1);

        finish_run();
    end
endmodule